// File: doc/BRIEF.md
# Move-Op Instruction Pair Fuser

This block sits in an instruction front end between predecode and issue. It takes a stream of predecoded two-operand records and emits a stream of three-operand internal operations, each with a register source, a general source and a destination. A register-to-register long move into data register Y, immediately followed by a long add whose destination is also Y, becomes a single operation `Y = src2 + X`. X is the move's source register and src2 is the add's source operand, which may be a memory operand. The pair issues as one operation in one clock.

Every record passes through a one-entry holding slot. A record that could open a pair waits there for its successor. If the successor completes a valid pair, the fused operation is offered at the same time as the successor is accepted. Otherwise the held record leaves unfused. So does a held record on any cycle with no input. Both streams use valid/ready handshakes.

Top module: `movop_fuser`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Whenever `out_valid` is 0, `in_ready` is 1.
- R2: Fusion applies when a held record is MOVE (class 0), size long (2), source kind data register (0), hint 1 and predicate 0. The next presented record must be ADD (class 1), size long, predicate 0, with the same destination. The output is then class ADD, size long, `out_s1` = move source register, second source = add's source, destination = Y, `out_fused` 1, `out_pred` 0. It is offered in the cycle the add is presented, and the add is accepted in that cycle.
- R3: An unfused record is offered in the cycle after it is accepted. Its class, size and predicate are copied, `out_s1` equals its destination, the second source is its own source, and `out_fused` is 0.
- R4: A move with hint 0 is never fused.
- R5: If either record of the pair is not size long, the pair is not fused.
- R6: If the add's source kind is data register (0) and its register number equals Y, the pair is not fused.
- R7: If either record has predicate 1, the pair is not fused.
- R8: Fusion needs strict adjacency. Any record between the two prevents it, as does a different destination or a non-ADD second record. A held record is emitted unfused on any cycle where `in_valid` is 0.
- R9: Output order equals input order. Every accepted record appears in exactly one output, and each fused output covers exactly two records.
- R10: While `out_valid` is 1, `out_ready` is 0 and a record is waiting at the input, the output stays valid and unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted when high with in_valid |
| in_cls | input | 2 | Class: 0 move, 1 add, 2 subtract, 3 other |
| in_size | input | 2 | Size: 0 byte, 1 word, 2 long |
| in_src_kind | input | 3 | Source kind: 0 data reg, 1 address reg, 2 indirect, 3 postincrement, 4 predecrement, 5 immediate, 6 absolute |
| in_src_reg | input | REG_W | Source register number |
| in_dst | input | REG_W | Destination data register |
| in_hint | input | 1 | Pairing hint |
| in_pred | input | 1 | Record is predicated |
| out_valid | output | 1 | Output operation valid |
| out_ready | input | 1 | Consumer accepts output |
| out_cls | output | 2 | Operation class |
| out_size | output | 2 | Operation size |
| out_s1 | output | REG_W | First (register) source |
| out_s2_kind | output | 3 | Second source kind |
| out_s2_reg | output | REG_W | Second source register |
| out_dst | output | REG_W | Destination register |
| out_pred | output | 1 | Operation is predicated |
| out_fused | output | 1 | Operation came from a pair |

## Verification
A corrupted holding slot shows on the very next clock. Either `out_valid` disagrees with the reference, or an emitted operation carries the wrong fields, or the order breaks. A wrong pairing decision shows in the same cycle the second record is presented: `out_fused`, `out_s1` or `out_cls` differ, and the following cycle's `out_valid` differs because the slot did or did not empty. A lost or duplicated record leaves the slot state out of step with the reference from then on, so every later cycle mismatches.

// File: rtl/movop_fuser.sv
`timescale 1ns/1ps
module movop_fuser #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [1:0]       in_size,
  input  logic [2:0]       in_src_kind,
  input  logic [REG_W-1:0] in_src_reg,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_hint,
  input  logic             in_pred,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_cls,
  output logic [1:0]       out_size,
  output logic [REG_W-1:0] out_s1,
  output logic [2:0]       out_s2_kind,
  output logic [REG_W-1:0] out_s2_reg,
  output logic [REG_W-1:0] out_dst,
  output logic             out_pred,
  output logic             out_fused
);
  localparam logic [1:0] CLS_MOVE = 2'd0;
  localparam logic [1:0] CLS_ADD  = 2'd1;
  localparam logic [1:0] SZ_LONG  = 2'd2;
  localparam logic [2:0] K_DREG   = 3'd0;

  logic             h_vld;
  logic [1:0]       h_cls, h_size;
  logic [2:0]       h_kind;
  logic [REG_W-1:0] h_sreg, h_dst;
  logic             h_hint, h_pred;

  logic head_ok, tail_ok, fuse, load;

  assign head_ok = h_vld && h_cls == CLS_MOVE && h_size == SZ_LONG &&
                   h_kind == K_DREG && h_hint && !h_pred;
  assign tail_ok = in_valid && in_cls == CLS_ADD && in_size == SZ_LONG &&
                   !in_pred && in_dst == h_dst &&
                   !(in_src_kind == K_DREG && in_src_reg == h_dst);
  assign fuse    = head_ok && tail_ok;

  assign out_valid = h_vld;
  assign in_ready  = !h_vld || out_ready;
  assign load      = in_valid && in_ready && !fuse;

  assign out_cls     = fuse ? CLS_ADD     : h_cls;
  assign out_size    = fuse ? SZ_LONG     : h_size;
  assign out_s1      = fuse ? h_sreg      : h_dst;
  assign out_s2_kind = fuse ? in_src_kind : h_kind;
  assign out_s2_reg  = fuse ? in_src_reg  : h_sreg;
  assign out_dst     = h_dst;
  assign out_pred    = fuse ? 1'b0        : h_pred;
  assign out_fused   = fuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= 1'b0;
    end else if (load) begin
      h_vld <= 1'b1;
    end else if (out_valid && out_ready) begin
      h_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      h_cls  <= in_cls;
      h_size <= in_size;
      h_kind <= in_src_kind;
      h_sreg <= in_src_reg;
      h_dst  <= in_dst;
      h_hint <= in_hint;
      h_pred <= in_pred;
    end
  end
endmodule

// File: rtl/movop_fuser_chk.sv
`timescale 1ns/1ps
module movop_fuser_chk #(
  parameter int REG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_cls,
  input logic [1:0]       out_size,
  input logic [REG_W-1:0] out_s1,
  input logic [2:0]       out_s2_kind,
  input logic [REG_W-1:0] out_s2_reg,
  input logic [REG_W-1:0] out_dst,
  input logic             out_pred,
  input logic             out_fused,
  input logic             h_hint,
  input logic             h_pred
);
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_fused_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_cls == 2'd1 && out_size == 2'd2 && !out_pred &&
                               in_valid && (in_ready == out_ready));

  p_plain_s1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fused |-> out_s1 == out_dst);

  // R4 and R7: the held move must carry the hint and no predicate
  p_hint_pred_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> h_hint && !h_pred);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && in_valid |=> out_valid &&
      $stable({out_cls, out_size, out_s1, out_s2_kind, out_s2_reg, out_dst, out_pred, out_fused}));
endmodule

bind movop_fuser movop_fuser_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
  .out_size(out_size), .out_s1(out_s1), .out_s2_kind(out_s2_kind),
  .out_s2_reg(out_s2_reg), .out_dst(out_dst), .out_pred(out_pred),
  .out_fused(out_fused), .h_hint(h_hint), .h_pred(h_pred)
);

// File: tb/movop_fuser_bench.sv
`timescale 1ns/1ps
module movop_fuser_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic in_valid = 0, out_ready = 0, in_hint = 0, in_pred = 0;
  logic [1:0] in_cls = 0, in_size = 0;
  logic [2:0] in_src_kind = 0, in_src_reg = 0, in_dst = 0;
  logic in_ready, out_valid, out_pred, out_fused;
  logic [1:0] out_cls, out_size;
  logic [2:0] out_s1, out_s2_kind, out_s2_reg, out_dst;

  movop_fuser u_movop_fuser (.*);

  // queue entry: [15] bubble, [14:13] cls, [12:11] size, [10:8] kind,
  // [7:5] src reg, [4:2] dst, [1] hint, [0] pred
  logic [15:0] q[$];
  int checks = 0, errors = 0;
  string tag = "R1";
  bit mv = 0;
  logic [14:0] mh;
  bit held = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int s, input int k, input int r, input int d, input int h, input int p);
    q.push_back({1'b0, 2'(c), 2'(s), 3'(k), 3'(r), 3'(d), 1'(h), 1'(p)});
  endtask

  function automatic bit pair_ok(input logic [14:0] h, input logic [14:0] x);
    bit head, tail;
    head = h[14:13] == 0 && h[12:11] == 2 && h[10:8] == 0 && h[1] && !h[0];
    tail = x[14:13] == 1 && x[12:11] == 2 && !x[0] && x[4:2] == h[4:2] &&
           !(x[10:8] == 0 && x[7:5] == h[4:2]);
    return head && tail;
  endfunction

  task automatic cycle(input int vpct, input int rpct);
    logic [14:0] x;
    bit fz, eready, acc;
    logic [17:0] ev, av;
    @(negedge clk);
    if (!held) begin
      if (q.size() > 0 && q[0][15]) begin
        void'(q.pop_front());
        in_valid = 0;
      end else begin
        in_valid = q.size() > 0 && ($urandom_range(99) < vpct);
      end
    end
    x = (q.size() > 0) ? q[0][14:0] : 15'h0;
    {in_cls, in_size, in_src_kind, in_src_reg, in_dst, in_hint, in_pred} = x;
    out_ready = $urandom_range(99) < rpct;
    #1;
    fz = mv && in_valid && pair_ok(mh, x);
    eready = !mv || out_ready;
    chk(out_valid == mv, "out_valid", 32'(out_valid), 32'(mv));
    chk(in_ready == eready, "in_ready", 32'(in_ready), 32'(eready));
    if (mv) begin
      if (fz) ev = {2'd1, 2'd2, mh[7:5], x[10:8], x[7:5], mh[4:2], 1'b0, 1'b1};
      else    ev = {mh[14:13], mh[12:11], mh[4:2], mh[10:8], mh[7:5], mh[4:2], mh[0], 1'b0};
      av = {out_cls, out_size, out_s1, out_s2_kind, out_s2_reg, out_dst, out_pred, out_fused};
      chk(av == ev, "op", 32'(av), 32'(ev));
    end
    acc = in_valid && eready;
    if (!mv) begin
      if (in_valid) begin mv = 1; mh = x; end
    end else if (out_ready) begin
      if (fz) mv = 0;
      else if (in_valid) mh = x;
      else mv = 0;
    end
    if (acc) void'(q.pop_front());
    held = in_valid && !acc;
  endtask

  task automatic run(input string t, input int vpct, input int rpct);
    tag = t;
    while (q.size() > 0) cycle(vpct, rpct);
    for (int i = 0; i < 8; i++) cycle(0, 100);
    chk(!mv && !out_valid && q.size() == 0, "drained R9", 32'(out_valid), 32'(0));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R1";
    chk(out_valid == 0, "reset out_valid", 32'(out_valid), 0);
    chk(in_ready == 1, "reset in_ready", 32'(in_ready), 1);

    // R2: move.l d1,d3 (hint) ; add.l (a0),d3 ; add.l #imm,d5 after move d2,d5
    push(0,2,0,1,3,1,0); push(1,2,2,0,3,0,0);
    push(0,2,0,2,5,1,0); push(1,2,5,0,5,0,0);
    push(0,2,0,4,6,1,0); push(1,2,0,2,6,0,0);
    run("R2", 100, 100);
    // R3: plain records
    push(1,2,0,2,4,0,0); push(2,1,3,1,7,1,0); push(3,0,6,0,0,0,1);
    run("R3", 100, 100);
    // R4: no hint
    push(0,2,0,1,3,0,0); push(1,2,2,0,3,0,0);
    run("R4", 100, 100);
    // R5: size mismatch either side
    push(0,1,0,1,3,1,0); push(1,2,2,0,3,0,0);
    push(0,2,0,1,3,1,0); push(1,1,2,0,3,0,0);
    run("R5", 100, 100);
    // R6: add source reads Y
    push(0,2,0,1,3,1,0); push(1,2,0,3,3,0,0);
    run("R6", 100, 100);
    // R7: predicated move, predicated add
    push(0,2,0,1,3,1,1); push(1,2,2,0,3,0,0);
    push(0,2,0,1,3,1,0); push(1,2,2,0,3,0,1);
    run("R7", 100, 100);
    // R8: record between, bubble between, other dst, non-add second
    push(0,2,0,1,3,1,0); push(3,2,2,0,0,0,0); push(1,2,2,0,3,0,0);
    push(0,2,0,1,3,1,0); q.push_back(16'h8000); push(1,2,2,0,3,0,0);
    push(0,2,0,1,3,1,0); push(1,2,2,0,4,0,0);
    push(0,2,0,1,3,1,0); push(2,2,2,0,3,0,0);
    run("R8", 100, 100);
    // R10: stalls on both sides
    for (int i = 0; i < 40; i++) begin push(0,2,0,i%8,2,1,0); push(1,2,i%7,1,2,0,0); end
    run("R10", 70, 40);
    // R9: random mix
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(2) == 0) push(0, $urandom_range(1)+1, $urandom_range(1), $urandom_range(7),
                                       $urandom_range(3), $urandom_range(3) != 0, $urandom_range(7) == 0);
      else push($urandom_range(3), $urandom_range(3) == 0 ? 1 : 2, $urandom_range(6), $urandom_range(7),
                $urandom_range(3), $urandom_range(1), $urandom_range(7) == 0);
      if ($urandom_range(15) == 0) q.push_back(16'h8000);
    end
    run("R9", 80, 75);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule